// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block holds the integer registers of a core that uses register windows for procedure calls. Instructions name one of 32 visible registers with a 5-bit number. Eight of those numbers always reach one fixed set of shared registers. The other 24 are resolved through a window pointer into a larger physical array of `8 + 8*16 = 136` words. Each window exposes an incoming group, a private local group and an outgoing group of eight registers each. The outgoing group of one window is the same storage as the incoming group of the window after it. A caller therefore leaves arguments in its outgoing registers, and after the call the callee finds them as its incoming registers. The windows form a ring, so the last window's outgoing group is the first window's incoming group.

A call strobe moves the pointer forward one window and a return strobe moves it back one window. A mask with one bit per window records which windows currently hold live state. A call is refused with an overflow indication when its target window is already live, which means the ring is full. A return is refused with an underflow indication when its target window is not live, which means there is nothing resident to return into. When a strobe is refused the pointer stays where it is, so that the handler outside this block can spill or fill windows and then retry.

Top module: `rwin_file`

## Requirements
- R1: Register numbers 0 to 7 are globals. They address the same storage whatever the window pointer holds.
- R2: Register numbers 16 to 23 are locals, private to each window. A write to a local in one window is not visible in any other window.
- R3: Register numbers 8 to 15 are the outgoing group of window w, and numbers 24 to 31 are the incoming group of window w. The outgoing register 8+k of window w is the same storage as incoming register 24+k of window w+1. An accepted call moves the pointer from w to w+1, so values written to 8..15 before the call read back on 24..31 after it.
- R4: Window numbers wrap modulo 8. The outgoing group of window 7 is the incoming group of window 0.
- R5: After reset the pointer selects window 0 and only window 0 is marked live. A return straight after reset therefore underflows, and seven calls in a row are accepted.
- R6: A call whose target window (pointer+1 mod 8) is marked live raises `overflow` combinationally in the strobe's cycle. The pointer and the mask stay unchanged.
- R7: A return whose target window (pointer-1 mod 8) is not marked live raises `underflow` combinationally in the strobe's cycle. The pointer and the mask stay unchanged.
- R8: An accepted return clears the live bit of the window being left and moves the pointer back by one. A later call into that window is therefore accepted.
- R9: A read port that addresses the register being written in the same cycle returns the value held before the write. The new value is visible from the next cycle on.
- R10: When `callReq` and `retReq` are asserted together, both are ignored. No status is raised and the pointer does not move.
- R11: A write issued in the same cycle as an accepted call lands in the window that was current before the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rdAddrA | input | 5 | Read port A register number |
| rdDataA | output | DATA_W | Read port A data (combinational) |
| rdAddrB | input | 5 | Read port B register number |
| rdDataB | output | DATA_W | Read port B data (combinational) |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write register number |
| wrData | input | DATA_W | Write data |
| callReq | input | 1 | Call strobe: advance one window |
| retReq | input | 1 | Return strobe: go back one window |
| overflow | output | 1 | Call refused, target window live |
| underflow | output | 1 | Return refused, target window not live |

## Verification
The hardest situations to reach are the ring-full and ring-empty edges. Reaching them needs a long run of accepted calls or returns from a known mask state, and at the full edge the window-7 outgoing group aliases the window-0 incoming group. The bench walks the pointer by calls through every window from reset until the eighth call overflows, writing distinct values into each window's locals and outgoing group and reading all 32 registers after every step. It then returns all the way down until a return underflows. A long pseudo-random mix of calls, returns, collisions and writes follows, checked against an arithmetic model of the mapping and the mask.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int WIN_BITS = 3;
  localparam int NWIN     = 1 << WIN_BITS;
  localparam int GRP_BITS = 3;
  localparam int GRP      = 1 << GRP_BITS;
  localparam int REG_BITS = GRP_BITS + 2;
  localparam int WSPAN    = 2 * GRP;
  localparam int PHYS_N   = GRP + NWIN * WSPAN;
  localparam int PHYS_W   = $clog2(PHYS_N);
  localparam int REL_W    = WIN_BITS + GRP_BITS + 1;
  localparam int NPORT    = 3;

  typedef struct packed {
    logic [WIN_BITS-1:0] winPtr;
  } winCtl_t;
endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate
  import rwin_pkg::*;
(
  input  logic [WIN_BITS-1:0] win,
  input  logic [REG_BITS-1:0] regNum,
  output logic [PHYS_W-1:0]   phys
);
  logic [GRP_BITS-1:0] low;
  logic [REL_W-1:0]    off;
  logic [REL_W-1:0]    rel;
  logic                isGlobal;

  assign low      = regNum[GRP_BITS-1:0];
  assign isGlobal = (regNum[REG_BITS-1:GRP_BITS] == 2'd0);

  always_comb begin
    case (regNum[REG_BITS-1:GRP_BITS])
      2'd1:    off = REL_W'(2 * GRP) + REL_W'(low);  // outgoing: next window's incoming
      2'd2:    off = REL_W'(GRP) + REL_W'(low);      // locals
      default: off = REL_W'(low);                    // incoming
    endcase
    // window base is win*16; the sum wraps naturally at NWIN*WSPAN
    rel = {win, {(GRP_BITS + 1){1'b0}}} + off;
    if (isGlobal) phys = PHYS_W'(low);
    else          phys = PHYS_W'(GRP) + PHYS_W'(rel);
  end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    callReq,
  input  logic    retReq,
  output winCtl_t ctl,
  output logic    overflow,
  output logic    underflow
);
  logic [WIN_BITS-1:0] winPtr;
  logic [WIN_BITS-1:0] nextWin;
  logic [WIN_BITS-1:0] prevWin;
  logic [NWIN-1:0]     winMask;
  logic soloCall, soloRet, callTake, retTake;

  assign nextWin  = winPtr + WIN_BITS'(1);
  assign prevWin  = winPtr - WIN_BITS'(1);
  assign soloCall = callReq & ~retReq;
  assign soloRet  = retReq & ~callReq;

  assign overflow  = soloCall & winMask[nextWin];
  assign underflow = soloRet & ~winMask[prevWin];
  assign callTake  = soloCall & ~winMask[nextWin];
  assign retTake   = soloRet & winMask[prevWin];

  always_ff @(posedge clk) begin
    if (rst) begin
      winPtr  <= '0;
      winMask <= NWIN'(1);
    end else if (callTake) begin
      winPtr           <= nextWin;
      winMask[nextWin] <= 1'b1;
    end else if (retTake) begin
      winMask[winPtr] <= 1'b0;
      winPtr          <= prevWin;
    end
  end

  assign ctl.winPtr = winPtr;

  p_stay_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    overflow |=> ($stable(winPtr) && $stable(winMask)));
  p_stay_unf_r7: assert property (@(posedge clk) disable iff (rst)
    underflow |=> ($stable(winPtr) && $stable(winMask)));
  p_call_step_r3: assert property (@(posedge clk) disable iff (rst)
    callTake |=> (winPtr == $past(winPtr) + WIN_BITS'(1)) && winMask[winPtr]);
  p_ret_clear_r8: assert property (@(posedge clk) disable iff (rst)
    retTake |=> (winPtr == $past(winPtr) - WIN_BITS'(1)) && !winMask[$past(winPtr)]);
  p_cur_valid_r5: assert property (@(posedge clk) disable iff (rst)
    winMask[winPtr]);
  p_status_excl_r10: assert property (@(posedge clk) disable iff (rst)
    (callReq && retReq) |-> (!overflow && !underflow) ##1 $stable(winPtr));
endmodule

// File: rtl/rwin_regs.sv
module rwin_regs
  import rwin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  winCtl_t             ctl,
  input  logic [REG_BITS-1:0] rdAddrA,
  input  logic [REG_BITS-1:0] rdAddrB,
  input  logic                wrEn,
  input  logic [REG_BITS-1:0] wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdDataA,
  output logic [DATA_W-1:0]   rdDataB
);
  logic [DATA_W-1:0]   regs [PHYS_N];
  logic [REG_BITS-1:0] portReg  [NPORT];
  logic [PHYS_W-1:0]   portPhys [NPORT];

  assign portReg[0] = rdAddrA;
  assign portReg[1] = rdAddrB;
  assign portReg[2] = wrAddr;

  for (genvar i = 0; i < NPORT; i++) begin : g_xl
    rwin_xlate u_xl (
      .win    (ctl.winPtr),
      .regNum (portReg[i]),
      .phys   (portPhys[i])
    );
  end

  always_ff @(posedge clk) begin
    if (wrEn) regs[portPhys[2]] <= wrData;
  end

  assign rdDataA = regs[portPhys[0]];
  assign rdDataB = regs[portPhys[1]];

  p_glob_fixed_r1: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA < REG_BITS'(GRP)) |-> (portPhys[0] == PHYS_W'(rdAddrA)));
  p_write_land_r9: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (regs[$past(portPhys[2])] == $past(wrData)));
  p_phys_range_r4: assert property (@(posedge clk) disable iff (rst)
    (portPhys[0] < PHYS_W'(PHYS_N)) && (portPhys[2] < PHYS_W'(PHYS_N)));
endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [REG_BITS-1:0] rdAddrA,
  output logic [DATA_W-1:0]   rdDataA,
  input  logic [REG_BITS-1:0] rdAddrB,
  output logic [DATA_W-1:0]   rdDataB,
  input  logic                wrEn,
  input  logic [REG_BITS-1:0] wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                callReq,
  input  logic                retReq,
  output logic                overflow,
  output logic                underflow
);
  winCtl_t ctl;

  rwin_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .callReq   (callReq),
    .retReq    (retReq),
    .ctl       (ctl),
    .overflow  (overflow),
    .underflow (underflow)
  );

  rwin_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );
endmodule

// File: tb/sim_rwin_file.sv
`timescale 1ns/1ps
module sim_rwin_file;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic wrEn = 1'b0, callReq = 1'b0, retReq = 1'b0;
  logic overflow, underflow;

  always #2 clk = ~clk;

  rwin_file #(.DATA_W(32)) u0 (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .callReq(callReq), .retReq(retReq),
    .overflow(overflow), .underflow(underflow)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] mem [136];
  bit written [136];
  int mPtr = 0;
  logic [7:0] mMask = 8'h01;
  logic [31:0] seed = 32'h0BAD_5EED;

  function automatic int physOf(int w, int r);
    if (r < 8)  return r;
    if (r >= 24) return 8 + ((w * 16 + (r - 24)) % 128);
    if (r >= 16) return 8 + ((w * 16 + 8 + (r - 16)) % 128);
    return 8 + (((w + 1) * 16 + (r - 8)) % 128);
  endfunction

  function automatic string regionTag(int r);
    if (r < 8)  return "R1";
    if (r < 16) return "R3";
    if (r < 24) return "R2";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit rt, input bit we, input int wa,
                      input logic [31:0] wd, input int ra, input int rb, input string tag);
    bit expOv, expUn;
    int pa, pb;
    @(negedge clk);
    callReq = c; retReq = rt; wrEn = we;
    wrAddr = wa[4:0]; wrData = wd; rdAddrA = ra[4:0]; rdAddrB = rb[4:0];
    #1;
    expOv = c && !rt && mMask[(mPtr + 1) % 8];
    expUn = rt && !c && !mMask[(mPtr + 7) % 8];
    if (c || rt) begin
      chk(overflow === expOv, tag, {31'd0, overflow}, {31'd0, expOv});
      chk(underflow === expUn, tag, {31'd0, underflow}, {31'd0, expUn});
    end
    pa = physOf(mPtr, ra);
    pb = physOf(mPtr, rb);
    if (written[pa]) chk(rdDataA === mem[pa], (we && wa == ra) ? "R9" : regionTag(ra), rdDataA, mem[pa]);
    if (written[pb]) chk(rdDataB === mem[pb], (we && wa == rb) ? "R9" : regionTag(rb), rdDataB, mem[pb]);
    @(posedge clk);
    if (we) begin
      mem[physOf(mPtr, wa)] = wd;
      written[physOf(mPtr, wa)] = 1'b1;
    end
    if (c && !rt && !expOv) begin
      mPtr = (mPtr + 1) % 8;
      mMask[mPtr] = 1'b1;
    end else if (rt && !c && !expUn) begin
      mMask[mPtr] = 1'b0;
      mPtr = (mPtr + 7) % 8;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    callReq = 0; retReq = 0; wrEn = 0;
  endtask

  task automatic readAll();
    for (int r = 0; r < 32; r++) step(0, 0, 0, 0, 32'h0, r, 31 - r, "");
  endtask

  task automatic peek(input int ra, input logic [31:0] exp, input string tag);
    @(negedge clk);
    callReq = 0; retReq = 0; wrEn = 0; rdAddrA = ra[4:0];
    #1;
    chk(rdDataA === exp, tag, rdDataA, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v4, v11, old;
    for (int i = 0; i < 136; i++) written[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(overflow === 1'b0 && underflow === 1'b0, "R5", {30'd0, overflow, underflow}, 32'd0);

    // fill window 0, all 32 registers
    for (int r = 0; r < 32; r++) step(0, 0, 1, r, 32'hA000_0000 | r, r, r, "");
    readAll();
    // return right after reset must underflow (R5, R7)
    step(0, 1, 0, 0, 0, 16, 24, "R5");
    step(0, 1, 0, 0, 0, 17, 25, "R7");
    readAll();

    // walk the ring by calls
    for (int k = 1; k < 8; k++) begin
      step(1, 0, 0, 0, 0, 0, 0, "R5");
      for (int r = 8; r < 24; r++) step(0, 0, 1, r, {8'hB0 + 8'(k), 16'd0, 8'(r)}, r, 24 + (r % 8), "R3");
      readAll();
    end
    v4 = 32'hC4C4_0007;
    step(0, 0, 1, 8, v4, 0, 0, "R4");
    step(1, 0, 0, 0, 0, 16, 8, "R6");
    readAll();

    // unwind to window 0, one extra return underflows
    for (int k = 0; k < 7; k++) begin
      step(0, 1, 0, 0, 0, 0, 0, "R8");
      readAll();
    end
    peek(24, v4, "R4");
    step(0, 1, 0, 0, 0, 20, 28, "R7");

    // both strobes together at window 0
    step(1, 1, 0, 0, 0, 16, 9, "R10");
    readAll();

    // read during write
    old = mem[physOf(mPtr, 18)];
    step(0, 0, 1, 18, 32'h9999_0018, 18, 18, "R9");
    peek(18, 32'h9999_0018, "R9");
    chk(old !== 32'h9999_0018, "R9", old, 32'h9999_0018);

    // write in the call cycle lands in the caller's window; re-entering window 1 works (R8)
    v11 = 32'h1111_000B;
    step(1, 0, 1, 8, v11, 0, 0, "R8");
    peek(24, v11, "R11");
    readAll();

    // pseudo-random mix
    for (int n = 0; n < 600; n++) begin
      bit c, rt;
      seed = seed * 32'd1103515245 + 32'd12345;
      c  = (seed[18:16] == 3'd0) || (seed[18:16] == 3'd7);
      rt = (seed[18:16] == 3'd1) || (seed[18:16] == 3'd7) || (seed[18:16] == 3'd2);
      step(c, rt, seed[20], int'(seed[25:21]), seed ^ 32'h5A5A_0000, int'(seed[30:26]),
           int'(seed[14:10]), (c && rt) ? "R10" : (c ? "R6" : "R7"));
    end
    idle();
    readAll();
    idle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule